// File: doc/BRIEF.md
# Intra 16x16 DC Predictor

This block forms the flat (DC) prediction for one 16x16 luma block. The caller presents the sixteen samples of the column to the left of the block and the sixteen samples of the row above it, all in parallel and 8 bits each. Two flags say which of those neighbour sets may be used. A single-cycle start pulse captures all of this. The block then reduces the usable samples to one fill value, with rounding. When no neighbour can be used, it falls back to mid-grey.

The prediction leaves as sixteen rows of sixteen identical bytes under a valid/ready handshake, one row per accepted transfer, with the row number alongside. A one-cycle done pulse marks the end of the burst. A start pulse that arrives while a burst is running is dropped. Any change on the sample or flag inputs after capture has no effect on the burst in progress.

Top module: `intra16_dc_pred`

## Requirements
- R1: With only the left flag set, the fill is (sum of the 16 left samples + 8) >> 4.
- R2: With only the above flag set, the fill is (sum of the 16 above samples + 8) >> 4.
- R3: With both flags set, the fill is (sum of all 32 samples + 16) >> 5, and all-255 inputs give 255 (no accumulator overflow).
- R4: With neither flag set, the fill is 128.
- R5: Each burst carries exactly 16 rows. Every row has the fill value in all 16 byte lanes, where lane k is `rowData[8k+7:8k]`.
- R6: `rowIdx` starts at 0 and rises by one only on a cycle where `rowValid` and `rowReady` are both high. While `rowValid` is high and `rowReady` is low, `rowIdx` and `rowValid` hold.
- R7: `done` is high for exactly one cycle. That cycle comes right after the transfer of row 15, and `rowValid` is low in it.
- R8: A start pulse during a burst is ignored. The running burst keeps its fill value, and no second burst follows.
- R9: The samples and flags are taken only on an accepted start. Changes to them during the burst do not alter the rows.
- R10: After reset, `rowValid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a prediction |
| leftAvail | input | 1 | Left neighbour column may be used |
| aboveAvail | input | 1 | Above neighbour row may be used |
| leftPix | input | 128 | Left samples; sample i in bits [8i+7:8i] |
| abovePix | input | 128 | Above samples; sample i in bits [8i+7:8i] |
| rowReady | input | 1 | Consumer accepts the current row |
| rowValid | output | 1 | A prediction row is presented |
| rowIdx | output | 4 | Number of the row presented |
| rowData | output | 128 | Prediction row, 16 byte lanes |
| done | output | 1 | One-cycle pulse after the last row |

## Verification
Some behaviours are checked by the assertions on every cycle. These are the handshake rules: the row number and valid hold under backpressure, done follows the last transfer as a single pulse with valid low, and the mid-grey fill is applied whenever neither flag was captured. The arithmetic of the three averaging cases is shown only by the bench's scenarios, which compare every row against a reference fill. The same holds for the rounding edge, the saturating all-255 case, the dropping of a start that arrives mid-burst, and the insensitivity to input changes after capture.

// File: rtl/dcpred_pkg.sv
package dcpred_pkg;
  typedef struct packed {
    logic capture;   // latch neighbours and flags
    logic compute;   // register the fill value
  } ctlStrobes_t;
endpackage

// File: rtl/dcpred_ctrl.sv
module dcpred_ctrl
  import dcpred_pkg::*;
#(
  parameter int ROWS = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic                    rowReady,
  output ctlStrobes_t             strb,
  output logic                    rowValid,
  output logic [$clog2(ROWS)-1:0] rowIdx,
  output logic                    done
);
  localparam int IDX_W = $clog2(ROWS);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ROWS - 1);

  typedef enum logic [1:0] {S_IDLE, S_CALC, S_EMIT, S_DONE} state_t;
  state_t state, stateNxt;
  logic [IDX_W-1:0] idxQ;
  logic xfer;

  assign xfer = (state == S_EMIT) && rowReady;

  always_comb begin
    stateNxt = state;
    strb = '0;
    unique case (state)
      S_IDLE: if (start) begin
        strb.capture = 1'b1;
        stateNxt = S_CALC;
      end
      S_CALC: begin
        strb.compute = 1'b1;
        stateNxt = S_EMIT;
      end
      S_EMIT: if (xfer && idxQ == LAST) stateNxt = S_DONE;
      S_DONE: stateNxt = S_IDLE;
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      idxQ  <= '0;
    end else begin
      state <= stateNxt;
      if (strb.compute)  idxQ <= '0;
      else if (xfer)     idxQ <= idxQ + 1'b1;
    end
  end

  assign rowValid = (state == S_EMIT);
  assign rowIdx   = idxQ;
  assign done     = (state == S_DONE);

  p_idx_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    rowValid && !rowReady |=> rowValid && $stable(rowIdx));
  p_idx_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    rowValid && rowReady && rowIdx != LAST |=> rowValid && rowIdx == $past(rowIdx) + 1'b1);
  p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rstN)
    rowValid && rowReady && rowIdx == LAST |=> done && !rowValid);
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_start_mid_r8: assert property (@(posedge clk) disable iff (!rstN)
    rowValid |-> !strb.capture);
endmodule

// File: rtl/dcpred_datapath.sv
module dcpred_datapath
  import dcpred_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int BLK      = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctlStrobes_t             strb,
  input  logic                    leftAvail,
  input  logic                    aboveAvail,
  input  logic [BLK*SAMPLE_W-1:0] leftPix,
  input  logic [BLK*SAMPLE_W-1:0] abovePix,
  output logic [BLK*SAMPLE_W-1:0] rowData
);
  localparam int SH1   = $clog2(BLK);
  localparam int SH2   = SH1 + 1;
  localparam int SUM_W = SAMPLE_W + SH1;
  localparam int TOT_W = SUM_W + 1;
  localparam logic [SAMPLE_W-1:0] MID = SAMPLE_W'(1 << (SAMPLE_W - 1));

  logic [BLK*SAMPLE_W-1:0] leftQ, aboveQ;
  logic leftQv, aboveQv;
  logic [SAMPLE_W-1:0] fillQ, fillNxt;
  logic [SUM_W-1:0] sumLeft, sumAbove;
  logic [TOT_W-1:0] sumBoth;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      leftQ   <= '0;
      aboveQ  <= '0;
      leftQv  <= 1'b0;
      aboveQv <= 1'b0;
      fillQ   <= '0;
    end else begin
      if (strb.capture) begin
        leftQ   <= leftPix;
        aboveQ  <= abovePix;
        leftQv  <= leftAvail;
        aboveQv <= aboveAvail;
      end
      if (strb.compute) fillQ <= fillNxt;
    end
  end

  always_comb begin
    sumLeft  = '0;
    sumAbove = '0;
    for (int i = 0; i < BLK; i++) begin
      sumLeft  = sumLeft  + SUM_W'(leftQ[i*SAMPLE_W +: SAMPLE_W]);
      sumAbove = sumAbove + SUM_W'(aboveQ[i*SAMPLE_W +: SAMPLE_W]);
    end
    sumBoth = TOT_W'(sumLeft) + TOT_W'(sumAbove);
  end

  always_comb begin
    unique case ({leftQv, aboveQv})
      2'b11:   fillNxt = SAMPLE_W'((sumBoth + TOT_W'(1 << (SH2 - 1))) >> SH2);
      2'b10:   fillNxt = SAMPLE_W'((sumLeft + SUM_W'(1 << (SH1 - 1))) >> SH1);
      2'b01:   fillNxt = SAMPLE_W'((sumAbove + SUM_W'(1 << (SH1 - 1))) >> SH1);
      default: fillNxt = MID;
    endcase
  end

  for (genvar k = 0; k < BLK; k++) begin : g_lane
    assign rowData[k*SAMPLE_W +: SAMPLE_W] = fillQ;
  end

  p_none_mid_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.compute && !leftQv && !aboveQv |=> fillQ == MID);
  p_fill_held_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.compute |=> fillQ == $past(fillQ));
endmodule

// File: rtl/intra16_dc_pred.sv
module intra16_dc_pred
  import dcpred_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int BLK      = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic                    leftAvail,
  input  logic                    aboveAvail,
  input  logic [BLK*SAMPLE_W-1:0] leftPix,
  input  logic [BLK*SAMPLE_W-1:0] abovePix,
  input  logic                    rowReady,
  output logic                    rowValid,
  output logic [$clog2(BLK)-1:0]  rowIdx,
  output logic [BLK*SAMPLE_W-1:0] rowData,
  output logic                    done
);
  ctlStrobes_t strb;

  dcpred_ctrl #(.ROWS(BLK)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .rowReady(rowReady),
    .strb(strb), .rowValid(rowValid), .rowIdx(rowIdx), .done(done)
  );

  dcpred_datapath #(.SAMPLE_W(SAMPLE_W), .BLK(BLK)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .leftAvail(leftAvail), .aboveAvail(aboveAvail),
    .leftPix(leftPix), .abovePix(abovePix), .rowData(rowData)
  );
endmodule

// File: tb/tb_intra16_dc_pred.sv
module tb_intra16_dc_pred;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, leftAvail = 1'b0, aboveAvail = 1'b0, rowReady = 1'b0;
  logic [127:0] leftPix = '0, abovePix = '0;
  logic rowValid, done;
  logic [3:0] rowIdx;
  logic [127:0] rowData;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  intra16_dc_pred dut (.*);

  function automatic int expFill(bit lf, bit af, logic [127:0] l, logic [127:0] a);
    int sl = 0, sa = 0;
    for (int i = 0; i < 16; i++) begin
      sl += int'(l[i*8 +: 8]);
      sa += int'(a[i*8 +: 8]);
    end
    if (lf && af) return (sl + sa + 16) / 32;
    if (lf) return (sl + 8) / 16;
    if (af) return (sa + 8) / 16;
    return 128;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // tag: requirement under test for fill value
  task automatic runBurst(bit lf, bit af, logic [127:0] l, logic [127:0] a,
                          string req, bit interfere);
    int exp = expFill(lf, af, l, a);
    int rows = 0, wait_n = 0, cyc = 0;
    bit lanesOk = 1, idxOk = 1, holdOk = 1;
    bit prevStall = 0;
    logic [3:0] prevIdx = '0;
    @(negedge clk);
    start = 1; leftAvail = lf; aboveAvail = af; leftPix = l; abovePix = a;
    @(negedge clk);
    start = 0;
    // R9: scramble inputs after capture
    leftAvail = ~lf; aboveAvail = ~af; leftPix = rnd128(); abovePix = rnd128();
    while (!rowValid && wait_n < 20) begin @(negedge clk); wait_n++; end
    while (rows < 16 && cyc < 400) begin
      if (rowValid) begin
        for (int k = 0; k < 16; k++)
          if (rowData[k*8 +: 8] !== 8'(exp)) lanesOk = 0;
        if (rowData[7:0] !== 8'(exp))
          check(0, req, "fill", rowData[7:0], exp);
        if (rowIdx !== 4'(rows)) idxOk = 0;
        if (prevStall && rowIdx !== prevIdx) holdOk = 0;
      end else idxOk = 0;
      if (interfere && rows == 5) begin
        start = 1; leftAvail = 1; aboveAvail = 0; leftPix = '1;
      end else start = 0;
      rowReady = ($urandom % 4) != 0;
      prevStall = rowValid && !rowReady;
      prevIdx = rowIdx;
      if (rowValid && rowReady) rows++;
      @(negedge clk);
      cyc++;
    end
    start = 0;
    rowReady = 0;
    check(rows == 16, "R5", "rows in burst", rows, 16);
    check(lanesOk, "R5", "all lanes equal fill", lanesOk, 1);
    check(idxOk, "R6", "row index sequence", idxOk, 1);
    check(holdOk, "R6", "index held under stall", holdOk, 1);
    check(done === 1'b1 && rowValid === 1'b0, "R7", "done after last row", {done, rowValid}, 2'b10);
    @(negedge clk);
    check(done === 1'b0, "R7", "done single cycle", done, 0);
    if (interfere) begin
      @(negedge clk);
      @(negedge clk);
      check(rowValid === 1'b0, "R8", "no burst from ignored start", rowValid, 0);
    end
  endtask

  initial begin
    #(200000 * 20);
    check(0, "WDOG", "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    logic [127:0] t;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    check(rowValid === 1'b0 && done === 1'b0, "R10", "reset outputs", {rowValid, done}, 0);
    rstN = 1;
    @(negedge clk);
    runBurst(0, 0, rnd128(), rnd128(), "R4", 0);
    runBurst(1, 0, '1, rnd128(), "R1", 0);
    t = '0; t[7:0] = 8'd8;
    runBurst(1, 0, t, '1, "R1", 0);            // sum 8 -> 1
    t[7:0] = 8'd7;
    runBurst(1, 0, t, '1, "R1", 0);            // sum 7 -> 0
    runBurst(0, 1, rnd128(), rnd128(), "R2", 0);
    runBurst(1, 1, '1, '1, "R3", 0);           // 8160 -> 255
    runBurst(1, 1, '0, '0, "R3", 0);
    runBurst(1, 1, rnd128(), rnd128(), "R8", 1);
    runBurst(0, 1, rnd128(), rnd128(), "R9", 0);
    for (int n = 0; n < 8; n++) begin
      bit lf = 1'($urandom), af = 1'($urandom);
      runBurst(lf, af, rnd128(), rnd128(), lf && af ? "R3" : lf ? "R1" : af ? "R2" : "R4", 0);
    end
    finishRun();
  end
endmodule